// File: doc/BRIEF.md
# UART Transmitter with Break and Parity

This block turns bytes into an asynchronous serial bit stream on a single transmit line. It is paced by a one-cycle pulse that arrives sixteen times per bit period from an external baud-rate generator. A byte enters through a valid/ready handshake. The block then sends a low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Each bit lasts sixteen pulses.

Three control inputs shape the frames. The first turns the parity bit on or off. The second chooses whether the parity bit makes the count of ones odd or even. The third requests a break, which holds the line low. A break request never cuts a character short: the frame in progress completes, and only then is the line pulled low. When the request is withdrawn, the line returns high and stays high for one whole bit period before another byte is taken. The parity controls are captured when a byte is accepted, so a frame is never built from a mix of settings.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, and whenever the block is idle with no break requested, `txd_o` is 1, `ready_o` is 1 and `busy_o` is 0.
- R2: A frame begins with a start bit at 0, followed by the 8 data bits with bit 0 first.
- R3: Every bit of a frame occupies exactly 16 `tick16_i` pulses, and the bit timer advances only on those pulses. A frame without parity therefore ends 160 pulses after acceptance, and a frame with parity ends 176 pulses after acceptance.
- R4: When `par_en_i` is 0, the stop bit comes directly after data bit 7 and the frame holds 10 bits.
- R5: When `par_en_i` is 1, one parity bit is placed between data bit 7 and the stop bit, and the frame holds 11 bits.
- R6: When `par_even_i` is 1, the parity bit makes the number of ones across the 8 data bits and the parity bit even. When it is 0, that number is odd.
- R7: While `par_en_i` is 0, `par_even_i` has no effect: the frame is the same for both of its values.
- R8: `par_en_i`, `par_even_i` and the byte are captured on the accepting clock edge. Changes to them during a frame do not alter that frame.
- R9: A byte is accepted on a clock edge where `valid_i` and `ready_o` are both 1. `ready_o` is 0 and `busy_o` is 1 while a frame, a break or the post-break idle bit is in progress.
- R10: A break request raised during a frame lets that frame finish unchanged. From the end of its stop bit, `txd_o` stays 0 for as long as `brk_i` stays 1, including spans of two frame times or more.
- R11: A break request raised while idle drives `txd_o` to 0 from the next clock edge, and `ready_o` drops at once.
- R12: The stop bit is 1.
- R13: After `brk_i` falls, `txd_o` is 1 and `ready_o` stays 0 for one full bit time (16 pulses). After that the block is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | One-cycle pulse, 16 per bit period |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte on `data_i` is offered |
| ready_o | output | 1 | Block accepts a byte this cycle |
| par_en_i | input | 1 | 1 inserts a parity bit |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| brk_i | input | 1 | Request to hold the line low |
| txd_o | output | 1 | Serial transmit line, idle high |
| busy_o | output | 1 | Frame, break or recovery bit in progress |

## Verification
Some properties are checked on every cycle. Ready never coincides with busy. An accepted byte always produces a low line on the next edge. The stop bit is high. The line stays low while a break is held. The recovery bit is high and never ready. The bit timer does not move without a pulse. The shift register holds its value between bit boundaries. Other behaviour shows only in the bench's scenarios: that each data bit lands in its right slot, that the parity bit has the right value and sense, that frames are exactly 160 or 176 pulses long, that controls changed mid-frame are ignored, and that the break length and recovery bit are correct.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_DATA    = 3'd2,
        ST_PARITY  = 3'd3,
        ST_STOP    = 3'd4,
        ST_BREAK   = 3'd5,
        ST_RECOVER = 3'd6
    } tx_state_e;

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic tick_i,
    output logic bit_end_o
);
    localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign bit_end_o = tick_i && !clr_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R3: the timer only moves on a pulse or a clear
    a_r3_cnt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              even_i,
    output logic              par_o
);
    logic [DATA_W:0] chain;

    assign chain[0] = ~even_i;

    for (genvar g = 0; g < DATA_W; g++) begin : g_xor
        assign chain[g+1] = chain[g] ^ data_i[g];
    end

    assign par_o = chain[DATA_W];

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              lsb_o,
    output logic              nxt_o
);
    logic [DATA_W-1:0] sh_d, sh_q;

    assign lsb_o = sh_q[0];
    assign nxt_o = sh_q[1];

    always_comb begin
        sh_d = sh_q;
        if (load_i)       sh_d = data_i;
        else if (shift_i) sh_d = {1'b0, sh_q[DATA_W-1:1]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    // R8: captured byte is untouched between bit boundaries
    a_r8_shift_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !shift_i) |=> $stable(sh_q));

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick16_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic              brk_i,
    output logic              txd_o,
    output logic              busy_o
);
    import uart_tx_pkg::*;

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e        state;
        logic [IDX_W-1:0] idx;
        logic             par_en;
        logic             par_bit;
        logic             txd;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        state:   ST_IDLE,
        idx:     '0,
        par_en:  1'b0,
        par_bit: 1'b0,
        txd:     1'b1
    };

    regs_t r_d, r_q;

    logic tmr_clr, bit_end;
    logic sh_load, sh_shift, sh_lsb, sh_nxt;
    logic par_calc;

    uart_tx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (tmr_clr),
        .tick_i    (tick16_i),
        .bit_end_o (bit_end)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (sh_load),
        .shift_i (sh_shift),
        .data_i  (data_i),
        .lsb_o   (sh_lsb),
        .nxt_o   (sh_nxt)
    );

    uart_tx_parity #(.DATA_W(DATA_W)) u_parity (
        .data_i (data_i),
        .even_i (par_even_i),
        .par_o  (par_calc)
    );

    assign ready_o = (r_q.state == ST_IDLE) && !brk_i;
    assign busy_o  = (r_q.state != ST_IDLE);
    assign txd_o   = r_q.txd;

    always_comb begin
        r_d      = r_q;
        tmr_clr  = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                r_d.txd = 1'b1;
                if (brk_i) begin
                    r_d.state = ST_BREAK;
                    r_d.txd   = 1'b0;
                end else if (valid_i) begin
                    sh_load     = 1'b1;
                    tmr_clr     = 1'b1;
                    r_d.state   = ST_START;
                    r_d.txd     = 1'b0;
                    r_d.par_en  = par_en_i;
                    r_d.par_bit = par_calc;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    r_d.state = ST_DATA;
                    r_d.idx   = '0;
                    r_d.txd   = sh_lsb;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (r_q.idx == LAST_IDX) begin
                        if (r_q.par_en) begin
                            r_d.state = ST_PARITY;
                            r_d.txd   = r_q.par_bit;
                        end else begin
                            r_d.state = ST_STOP;
                            r_d.txd   = 1'b1;
                        end
                    end else begin
                        sh_shift = 1'b1;
                        r_d.idx  = r_q.idx + 1'b1;
                        r_d.txd  = sh_nxt;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_end) begin
                    r_d.state = ST_STOP;
                    r_d.txd   = 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (brk_i) begin
                        r_d.state = ST_BREAK;
                        r_d.txd   = 1'b0;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.txd   = 1'b1;
                    end
                end
            end
            ST_BREAK: begin
                r_d.txd = 1'b0;
                if (!brk_i) begin
                    r_d.state = ST_RECOVER;
                    r_d.txd   = 1'b1;
                    tmr_clr   = 1'b1;
                end
            end
            ST_RECOVER: begin
                r_d.txd = 1'b1;
                if (bit_end) r_d.state = ST_IDLE;
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= RESET_VAL;
        else         r_q <= r_d;
    end

    // R9: handshake only while idle
    a_r9_ready_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> !busy_o);

    // R9, R2: an accepted byte starts a frame with a low start bit
    a_r9_accept_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_o) |=> (busy_o && !txd_o));

    // R12: stop bit is high
    a_r12_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_STOP) |-> txd_o);

    // R10: line held low while break stays requested
    a_r10_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((r_q.state == ST_BREAK) && brk_i) |=> !txd_o);

    // R13: recovery bit is high and not ready
    a_r13_recover_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RECOVER) |-> (txd_o && !ready_o));

endmodule

// File: tb/uart_tx_brk_tb.sv
`timescale 1ns/1ps
module uart_tx_brk_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] data = '0;
    logic       valid = 1'b0;
    logic       pen = 1'b0;
    logic       ev = 1'b0;
    logic       brk = 1'b0;
    logic       ready, txd, busy;

    int errors = 0;
    int checks = 0;
    int div = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tick = (div == 3);
        div  = (div + 1) % 4;
    end

    uart_tx_brk u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick16_i   (tick),
        .data_i     (data),
        .valid_i    (valid),
        .ready_o    (ready),
        .par_en_i   (pen),
        .par_even_i (ev),
        .brk_i      (brk),
        .txd_o      (txd),
        .busy_o     (busy)
    );

    // {par_en, par_even, data}
    localparam logic [9:0] VEC [0:7] = '{
        {1'b0, 1'b0, 8'h00},
        {1'b1, 1'b1, 8'hFF},
        {1'b1, 1'b0, 8'hA5},
        {1'b1, 1'b1, 8'h01},
        {1'b1, 1'b0, 8'h80},
        {1'b0, 1'b1, 8'h3C},
        {1'b0, 1'b0, 8'h3C},
        {1'b1, 1'b1, 8'h7E}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic handshake(input logic [7:0] d, input logic p, input logic e);
        @(negedge clk);
        while (!ready) @(negedge clk);
        data = d; pen = p; ev = e; valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] d, input logic p, input logic e,
                             input int brk_tick, input int chg_tick,
                             output logic [10:0] bits, output logic busy_pre,
                             output logic busy_end, output int rdy_hi);
        int nb;
        nb = p ? 11 : 10;
        bits = '0; busy_pre = 1'b0; rdy_hi = 0;
        handshake(d, p, e);
        for (int k = 1; k <= nb * 16; k++) begin
            wait_tick();
            if (k == brk_tick) brk = 1'b1;
            if (k == chg_tick) begin
                pen = ~pen; ev = ~ev; data = ~data;
            end
            if (k % 16 == 8) begin
                bits[k/16] = txd;
                if (ready) rdy_hi++;
            end
            if (k == nb * 16 - 1) busy_pre = busy;
        end
        busy_end = busy;
    endtask

    task automatic check_frame(input logic [7:0] d, input logic p, input logic e,
                               input logic [10:0] bits, input logic busy_pre,
                               input logic busy_end, input int rdy_hi,
                               input bit brk_follows);
        logic par_exp;
        par_exp = e ? ^d : ~^d;
        chk(bits[0] == 1'b0, "R2 start bit", bits[0], 0);
        chk(bits[8:1] == d, "R2 data LSB first", bits[8:1], d);
        if (p) begin
            chk(bits[9] == par_exp, "R5/R6 parity bit", bits[9], par_exp);
            chk(bits[10] == 1'b1, "R12 stop after parity", bits[10], 1);
        end else begin
            chk(bits[9] == 1'b1, "R4 stop right after data", bits[9], 1);
        end
        chk(rdy_hi == 0, "R9 ready low in frame", rdy_hi, 0);
        chk(busy_pre == 1'b1, "R3 busy until last pulse", busy_pre, 1);
        if (brk_follows) begin
            chk(txd == 1'b0, "R10 low after stop", txd, 0);
        end else begin
            chk(busy_end == 1'b0, "R3 frame length", busy_end, 0);
        end
    endtask

    task automatic hold_break_and_release();
        int bad_txd, bad_rdy;
        bad_txd = 0; bad_rdy = 0;
        for (int k = 0; k < 2 * 11 * 16; k++) begin
            wait_tick();
            if (txd !== 1'b0) bad_txd++;
            if (ready !== 1'b0) bad_rdy++;
        end
        chk(bad_txd == 0, "R10 line low two frames", bad_txd, 0);
        chk(bad_rdy == 0, "R9 not ready in break", bad_rdy, 0);
        @(negedge clk);
        brk = 1'b0;
        for (int k = 1; k <= 20; k++) begin
            wait_tick();
            if (k == 1) chk(txd == 1'b1, "R13 line high after break", txd, 1);
            if (k == 14) chk(!ready && txd, "R13 idle bit not ready", {ready, txd}, 1);
            if (k == 20) chk(ready == 1'b1, "R13 ready after idle bit", ready, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [10:0] bits, bits_b;
        logic bp, be;
        int rh;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1 && ready == 1'b1 && busy == 1'b0, "R1 reset idle",
            {txd, ready, busy}, 3'b110);

        // table of frames
        for (int i = 0; i < 8; i++) begin
            run_frame(VEC[i][7:0], VEC[i][9], VEC[i][8], 0, 0, bits, bp, be, rh);
            check_frame(VEC[i][7:0], VEC[i][9], VEC[i][8], bits, bp, be, rh, 1'b0);
        end

        // R7: parity sense ignored without parity
        run_frame(8'h5A, 1'b0, 1'b0, 0, 0, bits, bp, be, rh);
        run_frame(8'h5A, 1'b0, 1'b1, 0, 0, bits_b, bp, be, rh);
        chk(bits == bits_b, "R7 sense ignored when disabled", bits_b, bits);

        // R8: controls and byte changed mid-frame
        run_frame(8'h96, 1'b1, 1'b0, 0, 30, bits, bp, be, rh);
        check_frame(8'h96, 1'b1, 1'b0, bits, bp, be, rh, 1'b0);
        chk(bits[9] == 1'b1, "R8 parity from captured sense", bits[9], 1);

        // R1 idle after frames
        @(negedge clk);
        chk(txd && ready && !busy, "R1 idle between frames", {txd, ready, busy}, 3'b110);

        // R10: break requested mid-frame
        run_frame(8'hC3, 1'b1, 1'b1, 40, 0, bits, bp, be, rh);
        check_frame(8'hC3, 1'b1, 1'b1, bits, bp, be, rh, 1'b1);
        chk(busy == 1'b1, "R9 busy in break", busy, 1);
        hold_break_and_release();

        // R11: break from idle
        @(negedge clk);
        brk = 1'b1;
        #1;
        chk(ready == 1'b0, "R11 ready drops at once", ready, 0);
        @(negedge clk);
        chk(txd == 1'b0 && busy == 1'b1, "R11 low next edge", {txd, busy}, 2'b01);
        hold_break_and_release();

        // frame after break is normal
        run_frame(8'h69, 1'b1, 1'b0, 0, 0, bits, bp, be, rh);
        check_frame(8'h69, 1'b1, 1'b0, bits, bp, be, rh, 1'b0);

        // R1: reset mid-frame returns to idle
        handshake(8'h0F, 1'b1, 1'b1);
        repeat (5) wait_tick();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(txd && !busy, "R1 reset mid-frame", {txd, busy}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule